// File: doc/BRIEF.md
# Serial Word Store Bit-Bang Responder

This block stands in for a small serial word store (64 words of 16 bits by default) that host software reaches by toggling bits in a control register. Every host write to the serial control register updates a latched copy of the clock, select, data-in, request and write-enable bits. The new clock bit is compared with the latched one. A rising edge with select high shifts one command bit in. A falling edge steps the output bit pointer. A rising edge with select low drops all serial state. Once nine command bits have arrived and their top three bits form the read opcode, the pointer is aimed at the chosen word. Each later falling edge then presents the next bit on the data-out position of the register, most significant bit first, and runs on into the following word.

A second, parallel path lets the host write a word address into a lookup register and read the word back at once together with a done flag. Word contents are set at reset by an arithmetic rule taken from parameters, and a separate initialisation port can overwrite any single word. The serial path has two states. `SER_CMD` collects command bits. `SER_READ` streams data out. The transitions are `CMD_TO_READ`, taken on the ninth command bit when it carries the read opcode, and `ANY_TO_CMD`, taken on a rising clock with select low. Any other ninth bit stays in `SER_CMD` (`CMD_HOLD`).

Top module: `mw_eeprom_resp`

## Requirements
- R1: A write to the serial register latches clock (bit 0), select (bit 1), data-in (bit 2), write-enable (bits 5:4) and request (bit 6). A read of the register shows those latched bits at the same positions. All other written bits are dropped.
- R2: A read of the serial register always shows the grant bit (bit 7) and the present bit (bit 8) set.
- R3: A serial write whose clock bit equals the latched clock bit leaves the pointer, the command bit count and the read state unchanged.
- R4: A serial write that takes the clock bit from 1 to 0 advances the output bit pointer by one. The 10-bit pointer wraps from word 63 to word 0.
- R5: A serial write that takes the clock bit from 0 to 1 with select low clears the shift value and the bit count, and returns to `SER_CMD`.
- R6: A rising clock with select high shifts data-in into the LSB of the command shift value and increments the bit count, saturating at its maximum.
- R7: On the ninth command bit in `SER_CMD`, bits [8:6] of the shift value are compared with 3'b110. A match enters `SER_READ`. In both cases the pointer is loaded with address (bits [5:0]) times 16 minus 1.
- R8: In `SER_READ` the data-out bit (bit 3) is bit (15 − pointer[3:0]) of word pointer[9:4]. After the falling edge that follows the command, the word therefore streams MSB first and continues into the next word.
- R9: Outside `SER_READ` the data-out bit reads as 1.
- R10: A parallel write stores bits [15:0]. The address field is bits [15:8] and the start flag is bit 0. The parallel read returns the word in [31:16], the done flag in bit 4, and the stored bits [15:0] with bit 0 cleared.
- R11: A parallel address field above 63 makes the whole parallel read value zero.
- R12: At reset word i holds INIT_BASE + i·INIT_STEP (defaults 16'hA500 and 16'h0103, truncated to 16 bits). An initialisation port write replaces one word, and both read paths see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_wr | input | 1 | Write strobe for the serial control register |
| ser_wdata | input | 32 | Serial control write value |
| ser_rdata | output | 32 | Serial control read value with data-out, grant and present |
| par_wr | input | 1 | Write strobe for the parallel lookup register |
| par_wdata | input | 16 | Parallel lookup write value (address field and start flag) |
| par_rdata | output | 32 | Parallel lookup read value |
| init_we | input | 1 | Initialisation word write strobe |
| init_addr | input | 6 | Initialisation word address |
| init_data | input | 16 | Initialisation word value |

## Verification
Every register update takes effect on the clock edge that captures the write, and both read values are combinational from registers. Serial and parallel results are therefore due one cycle after the write strobe, and so is an initialisation write when it is read back. The bench drives each write on a falling edge, holds it across one rising edge, and samples at the next falling edge. The expected data-out bit comes from a bench copy of the word contents, indexed by a pointer the bench counts itself. That pointer starts at address·16 and steps on each falling edge the bench issues.

// File: rtl/mw_pkg.sv
package mw_pkg;
    // serial control register bit positions
    localparam int SK_BIT   = 0;
    localparam int CS_BIT   = 1;
    localparam int DI_BIT   = 2;
    localparam int DO_BIT   = 3;
    localparam int WEN_LO   = 4;
    localparam int WEN_HI   = 5;
    localparam int REQ_BIT  = 6;
    localparam int GNT_BIT  = 7;
    localparam int PRES_BIT = 8;

    // parallel lookup register layout
    localparam int PAR_START_BIT = 0;
    localparam int PAR_DONE_BIT  = 4;
    localparam int PAR_ADDR_LSB  = 8;
    localparam int PAR_ADDR_W    = 8;
    localparam int PAR_DATA_LSB  = 16;

    localparam logic [2:0] OP_READ = 3'b110;

    typedef enum logic [0:0] {
        SER_CMD  = 1'b0,
        SER_READ = 1'b1
    } ser_state_e;
endpackage

// File: rtl/mw_ctrl_latch.sv
module mw_ctrl_latch
    import mw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic [31:0] ctl_q,
    output logic        sk_rise,
    output logic        sk_fall,
    output logic        cs_new,
    output logic        di_new
);
    localparam logic [31:0] KEEP_MASK = (32'd1 << SK_BIT) | (32'd1 << CS_BIT) |
                                        (32'd1 << DI_BIT) | (32'd1 << WEN_LO) |
                                        (32'd1 << WEN_HI) | (32'd1 << REQ_BIT);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr)
            ctl_q <= wdata & KEEP_MASK;
    end

    always_comb begin
        sk_rise = wr && !ctl_q[SK_BIT] &&  wdata[SK_BIT];
        sk_fall = wr &&  ctl_q[SK_BIT] && !wdata[SK_BIT];
        cs_new  = wdata[CS_BIT];
        di_new  = wdata[DI_BIT];
    end
endmodule

// File: rtl/mw_serial_fsm.sv
module mw_serial_fsm
    import mw_pkg::*;
#(
    parameter int AW = 6,
    parameter int BW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sk_rise,
    input  logic                 sk_fall,
    input  logic                 cs,
    input  logic                 di,
    output logic                 reading,
    output logic [AW+BW-1:0]     ptr,
    output logic [$clog2(AW+3):0] cnt
);
    localparam int CMD_LEN = AW + 3;
    localparam int CNT_W   = $clog2(CMD_LEN) + 1;
    localparam int PTR_W   = AW + BW;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ser_state_e           state_q, state_d;
    logic [CMD_LEN-1:0]   shift_q, shift_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic [PTR_W-1:0]     ptr_q, ptr_d;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SER_CMD;
            shift_q <= '0;
            cnt_q   <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            shift_q <= shift_d;
            cnt_q   <= cnt_d;
            ptr_q   <= ptr_d;
        end
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        shift_d = shift_q;
        cnt_d   = cnt_q;
        ptr_d   = ptr_q;
        if (sk_fall) begin
            ptr_d = ptr_q + 1'b1;
        end else if (sk_rise) begin
            if (!cs) begin
                // ANY_TO_CMD
                state_d = SER_CMD;
                shift_d = '0;
                cnt_d   = '0;
                ptr_d   = '0;
            end else begin
                shift_d = {shift_q[CMD_LEN-2:0], di};
                cnt_d   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
                unique case (state_q)
                    SER_CMD: begin
                        if (cnt_d == CNT_W'(CMD_LEN)) begin
                            ptr_d = {shift_d[AW-1:0], {BW{1'b0}}} - 1'b1;
                            if (shift_d[AW+2:AW] == OP_READ)
                                state_d = SER_READ;   // CMD_TO_READ
                            else
                                state_d = SER_CMD;    // CMD_HOLD
                        end
                    end
                    SER_READ: state_d = SER_READ;
                endcase
            end
        end
    end

    // output process
    always_comb begin
        reading = (state_q == SER_READ);
        ptr     = ptr_q;
        cnt     = cnt_q;
    end
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int          WORDS     = 64,
    parameter int          WORD_W    = 16,
    parameter logic [15:0] INIT_BASE = 16'hA500,
    parameter logic [15:0] INIT_STEP = 16'h0103
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      init_we,
    input  logic [$clog2(WORDS)-1:0]  init_addr,
    input  logic [WORD_W-1:0]         init_data,
    input  logic [$clog2(WORDS)-1:0]  a_addr,
    output logic [WORD_W-1:0]         a_data,
    input  logic [$clog2(WORDS)-1:0]  b_addr,
    output logic [WORD_W-1:0]         b_data
);
    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++)
                mem[i] <= WORD_W'(INIT_BASE + 16'(i) * INIT_STEP);
        end else if (init_we) begin
            mem[init_addr] <= init_data;
        end
    end

    assign a_data = mem[a_addr];
    assign b_data = mem[b_addr];
endmodule

// File: rtl/mw_eeprom_resp.sv
module mw_eeprom_resp
    import mw_pkg::*;
#(
    parameter int          WORDS     = 64,
    parameter int          WORD_W    = 16,
    parameter logic [15:0] INIT_BASE = 16'hA500,
    parameter logic [15:0] INIT_STEP = 16'h0103
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_wr,
    input  logic [31:0]              ser_wdata,
    output logic [31:0]              ser_rdata,
    input  logic                     par_wr,
    input  logic [15:0]              par_wdata,
    output logic [31:0]              par_rdata,
    input  logic                     init_we,
    input  logic [$clog2(WORDS)-1:0] init_addr,
    input  logic [WORD_W-1:0]        init_data
);
    localparam int AW    = $clog2(WORDS);
    localparam int BW    = $clog2(WORD_W);
    localparam int PTR_W = AW + BW;
    localparam int CNT_W = $clog2(AW + 3) + 1;

    logic [31:0]       ctl_q;
    logic              sk_rise, sk_fall, cs_new, di_new;
    logic              reading;
    logic [PTR_W-1:0]  ptr;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] ser_word, par_word;
    logic [15:0]       par_q;
    logic [PAR_ADDR_W-1:0] par_idx;
    logic              par_in_range;
    logic              dout;

    mw_ctrl_latch u_latch (
        .clk(clk), .rst_n(rst_n), .wr(ser_wr), .wdata(ser_wdata),
        .ctl_q(ctl_q), .sk_rise(sk_rise), .sk_fall(sk_fall),
        .cs_new(cs_new), .di_new(di_new)
    );

    mw_serial_fsm #(.AW(AW), .BW(BW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sk_rise(sk_rise), .sk_fall(sk_fall),
        .cs(cs_new), .di(di_new), .reading(reading), .ptr(ptr), .cnt(cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            par_q <= '0;
        else if (par_wr)
            par_q <= par_wdata;
    end

    assign par_idx      = par_q[PAR_ADDR_LSB +: PAR_ADDR_W];
    assign par_in_range = (32'(par_idx) < WORDS);

    mw_word_store #(
        .WORDS(WORDS), .WORD_W(WORD_W),
        .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
        .a_addr(ptr[PTR_W-1:BW]), .a_data(ser_word),
        .b_addr(par_idx[AW-1:0]), .b_data(par_word)
    );

    // MSB first: bit index is the inverse of the low pointer bits
    assign dout = reading ? ser_word[~ptr[BW-1:0]] : 1'b1;

    always_comb begin
        ser_rdata           = ctl_q;
        ser_rdata[DO_BIT]   = dout;
        ser_rdata[GNT_BIT]  = 1'b1;
        ser_rdata[PRES_BIT] = 1'b1;
    end

    always_comb begin
        par_rdata = '0;
        if (par_in_range) begin
            par_rdata[15:0]                         = par_q;
            par_rdata[PAR_START_BIT]                = 1'b0;
            par_rdata[PAR_DONE_BIT]                 = 1'b1;
            par_rdata[PAR_DATA_LSB +: WORD_W]       = par_word;
        end
    end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
    parameter int WORDS  = 64,
    parameter int WORD_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ser_wr,
    input logic [31:0] ser_wdata,
    input logic [31:0] ser_rdata,
    input logic [31:0] par_rdata,
    input logic [31:0] ctl_q,
    input logic [15:0] par_q,
    input logic        reading,
    input logic [$clog2(WORDS)+$clog2(WORD_W)-1:0] ptr,
    input logic [$clog2($clog2(WORDS)+3):0]        cnt
);
    localparam int PTR_W = $clog2(WORDS) + $clog2(WORD_W);
    localparam int CNT_W = $clog2($clog2(WORDS) + 3) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_no_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_wr && ser_wdata[0] == ctl_q[0])
        |=> ($stable(ptr) && $stable(cnt) && $stable(reading)));

    assert_fall_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_wr && ctl_q[0] && !ser_wdata[0])
        |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    assert_deselect_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_wr && !ctl_q[0] && ser_wdata[0] && !ser_wdata[1])
        |=> (cnt == '0 && !reading));

    assert_shift_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_wr && !ctl_q[0] && ser_wdata[0] && ser_wdata[1] && cnt != CNT_MAX)
        |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_present_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_rdata[7] && ser_rdata[8]);

    assert_idle_dout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reading |-> ser_rdata[3]);

    assert_range_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(par_q[15:8]) >= WORDS) |-> (par_rdata == '0));
endmodule

bind mw_eeprom_resp mw_eeprom_chk #(.WORDS(WORDS), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_wr(ser_wr), .ser_wdata(ser_wdata),
    .ser_rdata(ser_rdata), .par_rdata(par_rdata), .ctl_q(ctl_q),
    .par_q(par_q), .reading(reading), .ptr(ptr), .cnt(cnt)
);

// File: tb/sim_mw_eeprom_resp.sv
`timescale 1ns/100ps
module sim_mw_eeprom_resp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_wr = 1'b0;
    logic [31:0] ser_wdata = '0;
    logic [31:0] ser_rdata;
    logic        par_wr = 1'b0;
    logic [15:0] par_wdata = '0;
    logic [31:0] par_rdata;
    logic        init_we = 1'b0;
    logic [5:0]  init_addr = '0;
    logic [15:0] init_data = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [15:0] ref_mem [64];

    always #2.5 clk = ~clk;

    mw_eeprom_resp u0 (
        .clk(clk), .rst_n(rst_n), .ser_wr(ser_wr), .ser_wdata(ser_wdata),
        .ser_rdata(ser_rdata), .par_wr(par_wr), .par_wdata(par_wdata),
        .par_rdata(par_rdata), .init_we(init_we), .init_addr(init_addr),
        .init_data(init_data)
    );

    function automatic logic [31:0] ctl(input bit sk, input bit cs, input bit di);
        return {29'd0, di, cs, sk};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic swr(input logic [31:0] d);
        @(negedge clk); ser_wr = 1'b1; ser_wdata = d;
        @(negedge clk); ser_wr = 1'b0;
    endtask

    task automatic pwr(input logic [15:0] d);
        @(negedge clk); par_wr = 1'b1; par_wdata = d;
        @(negedge clk); par_wr = 1'b0;
    endtask

    task automatic iwr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); init_we = 1'b1; init_addr = a; init_data = d;
        @(negedge clk); init_we = 1'b0;
        ref_mem[a] = d;
    endtask

    // deselect reset then nine command bits; ends with clock high
    task automatic send_cmd(input logic [2:0] op, input logic [5:0] addr);
        logic [8:0] bits;
        bits = {op, addr};
        swr(ctl(0, 0, 0));
        swr(ctl(1, 0, 0));
        for (int i = 8; i >= 0; i--) begin
            swr(ctl(0, 1, bits[i]));
            swr(ctl(1, 1, bits[i]));
        end
    endtask

    // falling edge, sample, rising edge; expected bit from bench pointer
    task automatic stream(input logic [5:0] addr, input int nbits, input bit expect_read, input string req);
        logic [9:0] p;
        logic exp;
        p = {addr, 4'd0};
        for (int k = 0; k < nbits; k++) begin
            swr(ctl(0, 1, 0));
            exp = expect_read ? ref_mem[p[9:4]][15 - p[3:0]] : 1'b1;
            check(32'(ser_rdata[3]), 32'(exp), req);
            swr(ctl(1, 1, 0));
            p = p + 1'b1;
        end
    endtask

    task automatic t_reset;
        check(ser_rdata, 32'h0000_0188, "R2/R9 reset serial read");
        check(par_rdata, {ref_mem[0], 16'h0010}, "R12/R10 reset parallel read word0");
    endtask

    task automatic t_latch;
        swr(32'hFFFF_FFFE);
        check(ser_rdata, 32'h0000_01FE, "R1 latched bits and mask");
        swr(32'h0000_0000);
        check(ser_rdata, 32'h0000_0188, "R1 latched bits cleared");
    endtask

    task automatic t_read_word;
        send_cmd(3'b110, 6'd5);
        stream(6'd5, 16, 1'b1, "R8/R7/R6 read word 5 MSB first");
    endtask

    task automatic t_wrap;
        send_cmd(3'b110, 6'd63);
        stream(6'd63, 20, 1'b1, "R4/R8 pointer runs across word 63 to 0");
    endtask

    task automatic t_no_edge;
        send_cmd(3'b110, 6'd7);
        swr(ctl(0, 1, 0));
        check(32'(ser_rdata[3]), 32'(ref_mem[7][15]), "R8 first bit word 7");
        swr(ctl(0, 1, 1));
        swr(ctl(0, 0, 1));
        check(32'(ser_rdata[3]), 32'(ref_mem[7][15]), "R3 same clock write no action");
        swr(ctl(1, 1, 0));
        swr(ctl(0, 1, 0));
        check(32'(ser_rdata[3]), 32'(ref_mem[7][14]), "R3 pointer kept after no-edge writes");
        check(ser_rdata & 32'h0000_0007, 32'h0000_0002, "R1 latched select and data-in");
    endtask

    task automatic t_bad_op;
        send_cmd(3'b101, 6'd5);
        stream(6'd5, 16, 1'b0, "R7/R9 non-read opcode keeps data-out high");
    endtask

    task automatic t_abort;
        send_cmd(3'b110, 6'd9);
        stream(6'd9, 3, 1'b1, "R8 word 9 partial");
        swr(ctl(0, 0, 0));
        swr(ctl(1, 0, 0));
        check(32'(ser_rdata[3]), 32'd1, "R5 deselect rising leaves read state");
        // partial command then abort again, count must restart
        for (int i = 0; i < 4; i++) begin
            swr(ctl(0, 1, 1));
            swr(ctl(1, 1, 1));
        end
        send_cmd(3'b110, 6'd12);
        stream(6'd12, 16, 1'b1, "R5/R6 fresh command after abort");
    endtask

    task automatic t_init;
        iwr(6'd10, 16'h1234);
        iwr(6'd63, 16'h8001);
        send_cmd(3'b110, 6'd10);
        stream(6'd10, 16, 1'b1, "R12 init word 10 serial");
        pwr(16'h0A21);
        check(par_rdata, {16'h1234, 16'h0A30}, "R12/R10 init word 10 parallel");
    endtask

    task automatic t_parallel;
        pwr(16'h3F01);
        check(par_rdata, {ref_mem[63], 16'h3F10}, "R10 start masked, word 63");
        pwr(16'h0300);
        check(par_rdata, {ref_mem[3], 16'h0310}, "R10 word 3");
        pwr(16'h4001);
        check(par_rdata, 32'h0, "R11 address 64 reads zero");
        pwr(16'hFF00);
        check(par_rdata, 32'h0, "R11 address 255 reads zero");
    endtask

    initial begin
        for (int i = 0; i < 64; i++)
            ref_mem[i] = 16'hA500 + 16'(i) * 16'h0103;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_latch;
        t_read_word;
        t_wrap;
        t_no_edge;
        t_bad_op;
        t_abort;
        t_init;
        t_parallel;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule